// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block sits on the host side of a 16-bit parallel NOR-style flash. It drives the device's asynchronous command bus to erase a run of consecutive blocks. A job is accepted on a valid/ready handshake. The job carries a starting block index and a block count minus one. For each block, the sequencer writes the two-cycle erase command to that block's base address. It then reads the status register again and again until the device reports ready.

When a run ends, the sticky error bits are decoded in a fixed priority order. On any error, the sequencer clears the status register. It always returns the device to read-array mode before it pulses `done` with a 3-bit result code. A configuration pin selects between two modes: checking status after every block, or deferring the check to the end of the run. A pair of level inputs lets the host suspend an erase in progress and resume it later.

The start channel has no buffering. `start_ready` is high only while the sequencer is idle, and a request is taken on the first rising clock edge where `start_valid` and `start_ready` are both high. The job fields must be stable in that cycle. After acceptance, the host waits for `done` before it offers the next job; `start_valid` has no effect while busy. All bus timing is set in system clock cycles by parameters.

Top module: `erase_seq`

## Requirements
- R1: `start_ready` is 1 exactly while idle. While idle the bus is quiet (`f_ce_n`, `f_we_n`, `f_oe_n` all 1). A handshake drops `start_ready` from the next cycle until the cycle after `done`.
- R2: Each block is erased by two write cycles to the address {block index, OFF_W zero bits}: data 20h, then data D0h. Blocks are processed in ascending order, starting at `start_blk`, for `start_nblk_m1`+1 blocks.
- R3: In a write cycle, `f_ce_n` is low and the data is driven (`f_dq_oe`=1) for exactly T_AS cycles before `f_we_n` falls. `f_we_n` then stays low for exactly T_WP cycles. `f_we_n` is never low while `f_ce_n` is high or `f_oe_n` is low.
- R4: After a confirm or resume, the status word is read repeatedly until bit 7 reads 1. Each read is its own `f_oe_n` low pulse of T_ACC cycles. `f_oe_n` stays high for at least two cycles between reads. `f_dq_oe` is 0 while `f_oe_n` is low.
- R5: When the run stops, the result is decoded by priority: status bit 1 set gives 1 (locked block); otherwise bit 3 set gives 2 (supply range error); otherwise bit 5 set gives 3 (erase failure); otherwise 0 (pass).
- R6: With `chk_defer`=0, the status is decoded after every block and the run stops at the first error. With `chk_defer`=1, decoding waits until the last block, except that a block ending with bit 3 set stops the run at once.
- R7: A nonzero result causes a write of 50h (clear status) to the last block's address before the final reset write.
- R8: Every run ends with a write of FFh (read-array) to the last block's address, before `done`.
- R9: `done` is a one-cycle pulse. In that cycle `result` holds the code (0..4), and `passed` is 1 exactly when `result` is 0.
- R10: If `susp_req` is high when a poll reads busy, the sequencer writes B0h and polls until bit 7 reads 1. It then leaves the bus quiet until `resume_req` is high, writes D0h and resumes polling.
- R11: If MAX_POLLS consecutive polls of one block read busy, the result is 4 (timeout), followed by the 50h and FFh writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Job request valid |
| start_ready | output | 1 | Sequencer idle, job can be taken |
| start_blk | input | ADDR_W-OFF_W | First block index |
| start_nblk_m1 | input | CNT_W | Number of blocks minus one |
| chk_defer | input | 1 | 1: decode status only at end of run |
| susp_req | input | 1 | Suspend request level |
| resume_req | input | 1 | Resume request level |
| done | output | 1 | One-cycle completion pulse |
| passed | output | 1 | Run passed (valid with done) |
| result | output | 3 | Result code (valid with done) |
| f_addr | output | ADDR_W | Flash address |
| f_dq_o | output | DQ_W | Flash write data |
| f_dq_oe | output | 1 | Data bus drive enable |
| f_dq_i | input | DQ_W | Flash read data |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write strobe, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach is a suspend followed by a resume in the middle of a poll loop. It requires the device to be busy at the moment `susp_req` is sampled, and then to report ready while suspended. The bench holds `susp_req` high before the job starts, so the first busy poll triggers it. A behavioural flash model in the bench answers the suspend with a ready status. The bench then watches the bus stay quiet and pulses `resume_req` for a single cycle. The deferred-mode case, where an error on a middle block must not stop the run, is reached by giving the model per-erase error bits that stay sticky until the clear command.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONF, S_POLL, S_SUSP, S_SPOLL,
    S_HOLD, S_RESUME, S_CLEAR, S_RESET, S_DONE
  } seq_st_t;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bus_st_t;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  localparam logic [2:0] RES_PASS    = 3'd0;
  localparam logic [2:0] RES_LOCKED  = 3'd1;
  localparam logic [2:0] RES_SUPPLY  = 3'd2;
  localparam logic [2:0] RES_FAIL    = 3'd3;
  localparam logic [2:0] RES_TIMEOUT = 3'd4;
endpackage

// File: rtl/esq_status_decode.sv
module esq_status_decode
  import erase_seq_pkg::*;
(
  input  logic       sr_locked,
  input  logic       sr_supply,
  input  logic       sr_fail,
  output logic [2:0] code
);
  always_comb begin
    if (sr_locked)      code = RES_LOCKED;
    else if (sr_supply) code = RES_SUPPLY;
    else if (sr_fail)   code = RES_FAIL;
    else                code = RES_PASS;
  end
endmodule

// File: rtl/esq_bus_cycle.sv
module esq_bus_cycle
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DQ_W   = 16,
  parameter int T_AS   = 2,
  parameter int T_WP   = 4,
  parameter int T_ACC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   data_i,
  output logic              ack,
  output logic [DQ_W-1:0]   rdata,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DQ_W-1:0]   f_dq_o,
  output logic              f_dq_oe,
  input  logic [DQ_W-1:0]   f_dq_i,
  output logic              f_ce_n,
  output logic              f_we_n,
  output logic              f_oe_n
);
  localparam int T_M1  = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int T_MAX = (T_M1 > T_ACC) ? T_M1 : T_ACC;
  localparam int CW    = $clog2(T_MAX + 1);

  bus_st_t           st;
  logic [CW-1:0]     cnt;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        B_IDLE: if (req) begin
          st     <= B_SETUP;
          cnt    <= CW'(T_AS - 1);
          rd_q   <= rd;
          addr_q <= addr_i;
          data_q <= data_i;
        end
        B_SETUP: if (cnt == '0) begin
          st  <= B_STROBE;
          cnt <= rd_q ? CW'(T_ACC - 1) : CW'(T_WP - 1);
        end else cnt <= cnt - 1'b1;
        B_STROBE: if (cnt == '0) begin
          st <= B_RECOV;
          if (rd_q) rdata <= f_dq_i;
        end else cnt <= cnt - 1'b1;
        default: st <= B_IDLE;
      endcase
    end
  end

  logic active;
  assign active  = (st == B_SETUP) || (st == B_STROBE);
  assign ack     = (st == B_RECOV);
  assign f_ce_n  = !active;
  assign f_we_n  = !((st == B_STROBE) && !rd_q);
  assign f_oe_n  = !((st == B_STROBE) && rd_q);
  assign f_dq_oe = active && !rd_q;
  assign f_addr  = addr_q;
  assign f_dq_o  = data_q;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int OFF_W     = 15,
  parameter int DQ_W      = 16,
  parameter int CNT_W     = 6,
  parameter int T_AS      = 2,
  parameter int T_WP      = 4,
  parameter int T_ACC     = 5,
  parameter int MAX_POLLS = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  output logic                    start_ready,
  input  logic [ADDR_W-OFF_W-1:0] start_blk,
  input  logic [CNT_W-1:0]        start_nblk_m1,
  input  logic                    chk_defer,
  input  logic                    susp_req,
  input  logic                    resume_req,
  output logic                    done,
  output logic                    passed,
  output logic [2:0]              result,
  output logic [ADDR_W-1:0]       f_addr,
  output logic [DQ_W-1:0]         f_dq_o,
  output logic                    f_dq_oe,
  input  logic [DQ_W-1:0]         f_dq_i,
  output logic                    f_ce_n,
  output logic                    f_we_n,
  output logic                    f_oe_n
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int PW    = $clog2(MAX_POLLS + 1);

  seq_st_t          st;
  logic [BLK_W-1:0] blk;
  logic [CNT_W-1:0] left;
  logic             defer_q;
  logic [PW-1:0]    polls;
  logic [2:0]       res;

  logic             bus_req, bus_rd, bus_ack;
  logic [7:0]       bus_cmd;
  logic [DQ_W-1:0]  rd_data;
  logic [2:0]       dec_code;
  logic             unused_bits;

  assign unused_bits = ^{rd_data[DQ_W-1:8], rd_data[6], rd_data[4], rd_data[2], rd_data[0]};

  always_comb begin
    bus_req = 1'b1;
    bus_rd  = 1'b0;
    bus_cmd = CMD_READ_ARRAY;
    case (st)
      S_SETUP:         bus_cmd = CMD_ERASE_SETUP;
      S_CONF,
      S_RESUME:        bus_cmd = CMD_CONFIRM;
      S_SUSP:          bus_cmd = CMD_SUSPEND;
      S_CLEAR:         bus_cmd = CMD_CLR_STATUS;
      S_RESET:         bus_cmd = CMD_READ_ARRAY;
      S_POLL, S_SPOLL: bus_rd  = 1'b1;
      default:         bus_req = 1'b0;
    endcase
  end

  esq_bus_cycle #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .T_AS(T_AS), .T_WP(T_WP), .T_ACC(T_ACC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .rd(bus_rd),
    .addr_i({blk, {OFF_W{1'b0}}}), .data_i(DQ_W'(bus_cmd)),
    .ack(bus_ack), .rdata(rd_data),
    .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe), .f_dq_i(f_dq_i),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
  );

  esq_status_decode u_dec (
    .sr_locked(rd_data[1]), .sr_supply(rd_data[3]), .sr_fail(rd_data[5]),
    .code(dec_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      blk     <= '0;
      left    <= '0;
      defer_q <= 1'b0;
      polls   <= '0;
      res     <= RES_PASS;
    end else begin
      case (st)
        S_IDLE: if (start_valid) begin
          blk     <= start_blk;
          left    <= start_nblk_m1;
          defer_q <= chk_defer;
          res     <= RES_PASS;
          st      <= S_SETUP;
        end
        S_SETUP: if (bus_ack) st <= S_CONF;
        S_CONF, S_RESUME: if (bus_ack) begin
          polls <= '0;
          st    <= S_POLL;
        end
        S_POLL: if (bus_ack) begin
          if (!rd_data[7]) begin
            if (polls == PW'(MAX_POLLS - 1)) begin
              res <= RES_TIMEOUT;
              st  <= S_CLEAR;
            end else begin
              polls <= polls + 1'b1;
              if (susp_req) st <= S_SUSP;
            end
          end else if (dec_code != RES_PASS &&
                       (!defer_q || left == '0 || rd_data[3])) begin
            res <= dec_code;
            st  <= S_CLEAR;
          end else if (left == '0) begin
            st <= S_RESET;
          end else begin
            blk  <= blk + 1'b1;
            left <= left - 1'b1;
            st   <= S_SETUP;
          end
        end
        S_SUSP:  if (bus_ack) st <= S_SPOLL;
        S_SPOLL: if (bus_ack && rd_data[7]) st <= S_HOLD;
        S_HOLD:  if (resume_req) st <= S_RESUME;
        S_CLEAR: if (bus_ack) st <= S_RESET;
        S_RESET: if (bus_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign start_ready = (st == S_IDLE);
  assign done        = (st == S_DONE);
  assign result      = res;
  assign passed      = done && (res == RES_PASS);
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ready,
  input logic       done,
  input logic [2:0] result,
  input logic       f_ce_n,
  input logic       f_we_n,
  input logic       f_oe_n,
  input logic       f_dq_oe
);
  assert_no_strobe_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!f_we_n && !f_oe_n));
  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> !f_ce_n);
  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !f_oe_n |-> !f_dq_oe);
  assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_oe_n) |=> f_oe_n);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (f_ce_n && f_we_n && f_oe_n));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd4));
endmodule

bind erase_seq erase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_ready(start_ready), .done(done),
  .result(result), .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n),
  .f_dq_oe(f_dq_oe)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
  localparam int ADDR_W = 12, OFF_W = 8, DQ_W = 16, CNT_W = 4;
  localparam int T_AS = 2, T_WP = 3, T_ACC = 2, MAX_POLLS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, chk_defer = 1'b0, susp_req = 1'b0, resume_req = 1'b0;
  logic [ADDR_W-OFF_W-1:0] start_blk = '0;
  logic [CNT_W-1:0] start_nblk_m1 = '0;
  logic start_ready, done, passed, f_dq_oe, f_ce_n, f_we_n, f_oe_n;
  logic [2:0] result;
  logic [ADDR_W-1:0] f_addr;
  logic [DQ_W-1:0] f_dq_o;
  logic [DQ_W-1:0] f_dq_i = '0;

  always #5 clk = ~clk;

  erase_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DQ_W(DQ_W), .CNT_W(CNT_W),
    .T_AS(T_AS), .T_WP(T_WP), .T_ACC(T_ACC), .MAX_POLLS(MAX_POLLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_blk(start_blk), .start_nblk_m1(start_nblk_m1), .chk_defer(chk_defer),
    .susp_req(susp_req), .resume_req(resume_req), .done(done), .passed(passed),
    .result(result), .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe),
    .f_dq_i(f_dq_i), .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n));

  int compared = 0, mismatched = 0;

  task automatic chk(string req, int act, int exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural flash model and reference state
  logic [7:0] err_cfg[8];
  int busy_cfg[8];
  int erase_idx = 0, busy_left = 0, reads = 0;
  bit armed = 0, suspended = 0, pend_v = 0;
  logic [7:0] pend = '0, sr = '0;
  logic [31:0] got_q[$], exp_q[$];
  bit prev_we = 1, prev_oe = 1, m_busy = 0, acc_pulse = 0;
  int su = 0, wlow = 0, olow = 0;

  always @(posedge clk) acc_pulse <= start_valid && start_ready;

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_pulse) m_busy = 1;
      chk("R1", start_ready, !m_busy, "start_ready vs model");
      if (!m_busy) chk("R1", f_ce_n, 1, "ce_n while idle");
      if (done) m_busy = 0;
      // write timing
      if (!f_ce_n && f_we_n && f_dq_oe) su++;
      if (prev_we && !f_we_n) begin chk("R3", su, T_AS, "setup cycles"); su = 0; end
      if (f_ce_n) su = 0;
      if (!f_we_n) wlow++;
      if (!f_oe_n) olow++;
      if (!prev_we && f_we_n) begin
        chk("R3", wlow, T_WP, "write pulse width");
        wlow = 0;
        got_q.push_back((32'(f_addr) << 8) | 32'(f_dq_o[7:0]));
        case (f_dq_o[7:0])
          8'h20: armed = 1;
          8'hD0: if (armed) begin
                   armed = 0; busy_left = busy_cfg[erase_idx];
                   pend = err_cfg[erase_idx]; pend_v = 1; erase_idx++;
                 end else suspended = 0;
          8'hB0: if (busy_left > 0) suspended = 1;
          8'h50: sr = '0;
          default: ;
        endcase
      end
      if (prev_oe && !f_oe_n) begin
        reads++;
        if (suspended) f_dq_i = 16'(8'hC0 | sr);
        else if (busy_left > 0) begin busy_left--; f_dq_i = 16'(sr); end
        else begin
          if (pend_v) begin sr = sr | pend; pend_v = 0; end
          f_dq_i = 16'(8'h80 | sr);
        end
      end
      if (!prev_oe && f_oe_n) begin chk("R4", olow, T_ACC, "read pulse width"); olow = 0; end
      prev_we = f_we_n;
      prev_oe = f_oe_n;
    end
  end

  function automatic logic [31:0] ent(int b, logic [7:0] d);
    return (32'(b) << (OFF_W + 8)) | 32'(d);
  endfunction

  task automatic cfg(logic [7:0] e0, logic [7:0] e1, logic [7:0] e2, int b);
    err_cfg[0] = e0; err_cfg[1] = e1; err_cfg[2] = e2;
    for (int i = 0; i < 8; i++) busy_cfg[i] = b;
    erase_idx = 0; busy_left = 0; reads = 0; suspended = 0;
    got_q.delete(); exp_q.delete();
  endtask

  task automatic launch(int b, int nm1, bit defer);
    @(negedge clk);
    start_blk = (ADDR_W-OFF_W)'(b); start_nblk_m1 = CNT_W'(nm1);
    chk_defer = defer; start_valid = 1;
    @(negedge clk);
    start_valid = 0;
  endtask

  task automatic finish_case(string req, int code, int exp_reads);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk("R9", done, 1, "done seen");
    chk(req, result, code, "result code");
    chk("R9", passed, code == 0, "passed flag");
    chk(req, got_q.size(), exp_q.size(), "command count");
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(req, got_q[i], exp_q[i], "command {addr,data}");
    if (exp_reads >= 0) chk("R4", reads, exp_reads, "status reads");
    @(negedge clk);
    chk("R9", done, 0, "done single cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", start_ready, 1, "reset ready");
    chk("R1", {f_ce_n, f_we_n, f_oe_n}, 3'b111, "reset strobes");
    chk("R9", done, 0, "reset done");

    // R2 R8: single block pass, 3 busy polls then ready
    cfg(8'h00, 8'h00, 8'h00, 3);
    exp_q = '{ent(5, 8'h20), ent(5, 8'hD0), ent(5, 8'hFF)};
    launch(5, 0, 0);
    finish_case("R2", 0, 4);

    // R5 priority: locked wins over supply and fail; R7 clear issued
    cfg(8'h2A, 8'h00, 8'h00, 1);
    exp_q = '{ent(1, 8'h20), ent(1, 8'hD0), ent(1, 8'h50), ent(1, 8'hFF)};
    launch(1, 0, 0);
    finish_case("R5", 1, -1);

    // R5: supply over fail
    cfg(8'h28, 8'h00, 8'h00, 1);
    exp_q = '{ent(2, 8'h20), ent(2, 8'hD0), ent(2, 8'h50), ent(2, 8'hFF)};
    launch(2, 0, 0);
    finish_case("R5", 2, -1);

    // R5 R7: fail alone
    cfg(8'h20, 8'h00, 8'h00, 0);
    exp_q = '{ent(3, 8'h20), ent(3, 8'hD0), ent(3, 8'h50), ent(3, 8'hFF)};
    launch(3, 0, 0);
    finish_case("R7", 3, -1);

    // R2: three blocks ascending, all pass
    cfg(8'h00, 8'h00, 8'h00, 2);
    exp_q = '{ent(2, 8'h20), ent(2, 8'hD0), ent(3, 8'h20), ent(3, 8'hD0),
              ent(4, 8'h20), ent(4, 8'hD0), ent(4, 8'hFF)};
    launch(2, 2, 0);
    finish_case("R2", 0, 9);

    // R6: per-block mode stops at failing second block
    cfg(8'h00, 8'h20, 8'h00, 1);
    exp_q = '{ent(2, 8'h20), ent(2, 8'hD0), ent(3, 8'h20), ent(3, 8'hD0),
              ent(3, 8'h50), ent(3, 8'hFF)};
    launch(2, 2, 0);
    finish_case("R6", 3, -1);

    // R6: deferred mode runs all blocks, sticky fail reported at end
    cfg(8'h00, 8'h20, 8'h00, 1);
    exp_q = '{ent(2, 8'h20), ent(2, 8'hD0), ent(3, 8'h20), ent(3, 8'hD0),
              ent(4, 8'h20), ent(4, 8'hD0), ent(4, 8'h50), ent(4, 8'hFF)};
    launch(2, 2, 1);
    finish_case("R6", 3, -1);

    // R6: deferred mode, supply error stops at once
    cfg(8'h08, 8'h00, 8'h00, 1);
    exp_q = '{ent(0, 8'h20), ent(0, 8'hD0), ent(0, 8'h50), ent(0, 8'hFF)};
    launch(0, 2, 1);
    finish_case("R6", 2, -1);

    // R11: device never ready
    cfg(8'h00, 8'h00, 8'h00, 1000);
    exp_q = '{ent(6, 8'h20), ent(6, 8'hD0), ent(6, 8'h50), ent(6, 8'hFF)};
    launch(6, 0, 0);
    finish_case("R11", 4, MAX_POLLS);

    // R10: suspend on first busy poll, hold, resume
    cfg(8'h00, 8'h00, 8'h00, 5);
    exp_q = '{ent(7, 8'h20), ent(7, 8'hD0), ent(7, 8'hB0), ent(7, 8'hD0), ent(7, 8'hFF)};
    susp_req = 1;
    launch(7, 0, 0);
    begin
      int n = 0;
      while (got_q.size() < 3 && n < 500) begin @(negedge clk); n++; end
    end
    repeat (30) @(negedge clk);
    chk("R10", got_q.size(), 3, "no command during hold");
    chk("R10", {f_ce_n, f_oe_n}, 2'b11, "bus quiet during hold");
    susp_req = 0; resume_req = 1;
    @(negedge clk);
    resume_req = 0;
    finish_case("R10", 0, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule